// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit sits beside a UART's data path and folds its interrupt sources into one request line and one identification byte. Software programs a 4-bit enable field through a byte-wide write port. The unit tracks which sources are pending and reports the most urgent enabled one. The receive path supplies two levels: data available and character timeout. Line status, transmitter empty and modem status arrive as single-cycle event pulses, which the unit latches until they are serviced.

A read strobe on the identification byte also serves as the acknowledge for a transmitter-empty interrupt. When the byte being read reports that source, the unit drops its pending flag and gives a one-cycle clear strobe to the transmitter logic. The identification byte also shows whether the FIFOs are enabled, in its two top bits, and shows a timeout in bit 3.

Top module: `uart_irq_ident`

## Requirements
- R1: A write stores `ier_wdata_i[3:0]` as the enables (bit 0 data available and timeout, bit 1 transmitter empty, bit 2 line status, bit 3 modem status). From the next cycle `ier_o` shows them. `ier_o[7:4]` always reads 0, whatever was written.
- R2: `iir_o[0]` is 0 when an enabled source is pending and 1 otherwise. `irq_o` is its inverse. After an enable write, the outcome follows the new enables from the cycle after the write.
- R3: `iir_o[3:1]` names the winning source in falling priority: line status 011, then data available 010 or timeout 110, then transmitter empty 001, then modem status 000. With nothing pending it reads 000.
- R4: Data available and timeout are live levels, both masked by enable bit 0. Timeout counts only while `fifo_en_i` is high. When both are present, 010 is reported.
- R5: A line status or modem status event sets a pending flag. The flag holds until `lsr_rd_i` or `msr_rd_i` clears it. If an event and a clear arrive in the same cycle, the flag stays set.
- R6: A transmitter-empty event sets a pending flag. When `iir_re_i` is high while `iir_o[3:0]` is 0010, `thre_clr_o` pulses in that cycle and the flag clears. A read that reports any other code leaves the flag set. An event in the clearing cycle keeps the flag set.
- R7: `iir_o[7:6]` is 11 while `fifo_en_i` is high and 00 otherwise. `iir_o[5:4]` is always 00. No input writes the identification byte directly.
- R8: A source that is pending while disabled stays latched. It is reported as soon as its enable is set.
- R9: After reset the enables are 0, no flag is pending, `iir_o` is 8'h01 with the FIFOs off, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| iir_re_i | input | 1 | Identification byte read strobe |
| lsr_evt_i | input | 1 | Receiver line status change pulse |
| lsr_rd_i | input | 1 | Line status serviced, clears its flag |
| rx_avail_i | input | 1 | Receive data available level |
| rx_tmo_i | input | 1 | Receive character timeout level |
| thre_evt_i | input | 1 | Transmitter holding empty pulse |
| msr_evt_i | input | 1 | Modem status change pulse |
| msr_rd_i | input | 1 | Modem status serviced, clears its flag |
| fifo_en_i | input | 1 | FIFOs enabled |
| ier_o | output | 8 | Enable register readback |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |
| thre_clr_o | output | 1 | Transmitter-empty cleared by read |

## Verification
The hardest case to reach is a stack of sources pending at once, each of which must then be peeled off in priority order. In that case a read must clear the transmitter-empty flag only while it is the reported source, and never while a higher source masks it. The stimulus first latches modem status, transmitter empty and line status behind open enables. It then adds the receive levels and retires one source per step, issuing reads both while transmitter empty is masked and while it is on top. Collisions between an event and its clear in one cycle, and sources latched while disabled and enabled later, are driven on purpose. A long random phase with sparse events follows.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned NUM_SRC = 5;

  // source slots, index 0 = highest priority
  localparam int unsigned SRC_LS   = 0;
  localparam int unsigned SRC_RDA  = 1;
  localparam int unsigned SRC_TMO  = 2;
  localparam int unsigned SRC_THRE = 3;
  localparam int unsigned SRC_MS   = 4;

  typedef enum logic [CODE_W-1:0] {
    ID_MS   = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_LS   = 3'b011,
    ID_TMO  = 3'b110
  } irq_id_e;

  // enable bit positions
  localparam int unsigned EN_RDA  = 0;
  localparam int unsigned EN_THRE = 1;
  localparam int unsigned EN_LS   = 2;
  localparam int unsigned EN_MS   = 3;
  localparam logic [REG_W-1:0] EN_USED = 8'h0F;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i & USED;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr_i[i]) flag_q <= 1'b0;
    end
    assign pend_o[i] = flag_q;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 5,
  parameter int unsigned CW = 3,
  parameter logic [N*CW-1:0] CODES = '0
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  sel_o
);
  always_comb begin
    sel_o  = '0;
    code_o = '0;
    // walk low to high priority so the lowest index ends up selected
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        sel_o      = '0;
        sel_o[i]   = 1'b1;
        code_o     = CODES[i*CW +: CW];
      end
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_we_i,
  input  logic [REG_W-1:0] ier_wdata_i,
  input  logic             iir_re_i,
  input  logic             lsr_evt_i,
  input  logic             lsr_rd_i,
  input  logic             rx_avail_i,
  input  logic             rx_tmo_i,
  input  logic             thre_evt_i,
  input  logic             msr_evt_i,
  input  logic             msr_rd_i,
  input  logic             fifo_en_i,
  output logic [REG_W-1:0] ier_o,
  output logic [REG_W-1:0] iir_o,
  output logic             irq_o,
  output logic             thre_clr_o
);
  localparam int unsigned NLATCH = 3;
  localparam int unsigned L_LS = 0, L_THRE = 1, L_MS = 2;
  localparam logic [NUM_SRC*CODE_W-1:0] CODE_TAB =
    {ID_MS, ID_THRE, ID_TMO, ID_RDA, ID_LS};

  logic [REG_W-1:0]   en;
  logic [NLATCH-1:0]  pend, lset, lclr;
  logic [NUM_SRC-1:0] req, sel;
  logic               any;
  logic [CODE_W-1:0]  code;

  irq_enable_reg #(.W(REG_W), .USED(EN_USED)) u_en (
    .clk_i, .rst_ni, .we_i(ier_we_i), .wdata_i(ier_wdata_i), .en_o(en)
  );

  assign lset = {msr_evt_i, thre_evt_i, lsr_evt_i};
  assign lclr = {msr_rd_i, thre_clr_o, lsr_rd_i};

  irq_pend_latch #(.N(NLATCH)) u_pend (
    .clk_i, .rst_ni, .set_i(lset), .clr_i(lclr), .pend_o(pend)
  );

  always_comb begin
    req           = '0;
    req[SRC_LS]   = pend[L_LS]   & en[EN_LS];
    req[SRC_RDA]  = rx_avail_i   & en[EN_RDA];
    req[SRC_TMO]  = rx_tmo_i     & fifo_en_i & en[EN_RDA];
    req[SRC_THRE] = pend[L_THRE] & en[EN_THRE];
    req[SRC_MS]   = pend[L_MS]   & en[EN_MS];
  end

  irq_prio_enc #(.N(NUM_SRC), .CW(CODE_W), .CODES(CODE_TAB)) u_enc (
    .req_i(req), .valid_o(any), .code_o(code), .sel_o(sel)
  );

  assign thre_clr_o = iir_re_i & sel[SRC_THRE];
  assign iir_o      = {{2{fifo_en_i}}, 2'b00, code, ~any};
  assign irq_o      = any;
  assign ier_o      = en;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ier_we_i,
  input logic [7:0] ier_wdata_i,
  input logic       iir_re_i,
  input logic       lsr_evt_i,
  input logic       thre_evt_i,
  input logic       fifo_en_i,
  input logic [7:0] ier_o,
  input logic [7:0] iir_o,
  input logic       irq_o,
  input logic       thre_clr_o
);
  p_ier_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_we_i |=> ier_o == {4'b0000, $past(ier_wdata_i[3:0])});

  p_irq_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir_o[0]);

  p_ls_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_evt_i && ier_o[2] && !ier_we_i) |=> iir_o[3:0] == 4'b0110);

  p_clr_only_on_thre_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_clr_o |-> (iir_re_i && iir_o[3:0] == 4'b0010));

  p_thre_gone_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thre_clr_o && !thre_evt_i) |=> iir_o[3:0] != 4'b0010);

  p_fifo_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[7:6] == {2{fifo_en_i}} && iir_o[5:4] == 2'b00);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ier_we = 0, iir_re = 0, lsr_evt = 0, lsr_rd = 0, rx_avail = 0, rx_tmo = 0;
  logic thre_evt = 0, msr_evt = 0, msr_rd = 0, fifo_en = 0;
  logic [7:0] ier_wdata = 0;
  logic [7:0] ier_o, iir_o;
  logic irq_o, thre_clr_o;

  int n_chk = 0, n_bad = 0;
  // reference state
  logic [3:0] m_en = 0;
  bit m_ls = 0, m_thre = 0, m_ms = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_irq_ident uut (
    .clk_i(clk), .rst_ni(rst_n), .ier_we_i(ier_we), .ier_wdata_i(ier_wdata),
    .iir_re_i(iir_re), .lsr_evt_i(lsr_evt), .lsr_rd_i(lsr_rd),
    .rx_avail_i(rx_avail), .rx_tmo_i(rx_tmo), .thre_evt_i(thre_evt),
    .msr_evt_i(msr_evt), .msr_rd_i(msr_rd), .fifo_en_i(fifo_en),
    .ier_o(ier_o), .iir_o(iir_o), .irq_o(irq_o), .thre_clr_o(thre_clr_o)
  );

  function automatic logic [7:0] exp_iir();
    logic [3:0] lo;
    if (m_ls && m_en[2])                         lo = 4'b0110;
    else if (rx_avail && m_en[0])                lo = 4'b0100;
    else if (rx_tmo && fifo_en && m_en[0])       lo = 4'b1100;
    else if (m_thre && m_en[1])                  lo = 4'b0010;
    else if (m_ms && m_en[3])                    lo = 4'b0000;
    else                                         lo = 4'b0001;
    return {fifo_en, fifo_en, 2'b00, lo};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against model, clock once, update model, clear pulses
  task automatic cyc();
    logic [7:0] e;
    bit clr;
    #1;
    e = exp_iir();
    clr = iir_re && e[3:0] == 4'b0010;
    chk("R1 ier_o", ier_o, {4'b0, m_en});
    chk("R2 irq_o", {7'b0, irq_o}, {7'b0, ~e[0]});
    chk("R3 iir_o[3:0]", {4'b0, iir_o[3:0]}, {4'b0, e[3:0]});
    chk("R7 iir_o[7:4]", {4'b0, iir_o[7:4]}, {4'b0, e[7:4]});
    chk("R6 thre_clr_o", {7'b0, thre_clr_o}, {7'b0, clr});
    @(posedge clk);
    if (ier_we) m_en = ier_wdata[3:0];
    m_ls   = lsr_evt  || (m_ls && !lsr_rd);
    m_ms   = msr_evt  || (m_ms && !msr_rd);
    m_thre = thre_evt || (m_thre && !clr);
    @(negedge clk);
    ier_we = 0; iir_re = 0; lsr_evt = 0; lsr_rd = 0;
    thre_evt = 0; msr_evt = 0; msr_rd = 0;
  endtask

  task automatic expect_iir(string tag, logic [7:0] v);
    #1 chk(tag, iir_o, v);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk);
    // R9 reset state
    chk("R9 iir_o reset", iir_o, 8'h01);
    chk("R9 irq_o reset", {7'b0, irq_o}, 8'h00);
    chk("R9 ier_o reset", ier_o, 8'h00);
    rst_n = 1;
    cyc();
    // R1 reserved bits drop
    ier_we = 1; ier_wdata = 8'hFF; cyc();
    chk("R1 ier_o readback", ier_o, 8'h0F);
    // R6 set, then read clears with strobe
    thre_evt = 1; cyc();
    expect_iir("R6 thre reported", 8'h02);
    iir_re = 1; #1 chk("R6 clr strobe", {7'b0, thre_clr_o}, 8'h01); cyc();
    expect_iir("R6 thre cleared", 8'h01);
    // R3 stacking order
    msr_evt = 1; cyc();
    expect_iir("R3 modem only", 8'h00);
    thre_evt = 1; cyc();
    expect_iir("R3 thre over modem", 8'h02);
    lsr_evt = 1; cyc();
    expect_iir("R3 line status top", 8'h06);
    rx_avail = 1;
    expect_iir("R3 ls over data", 8'h06);
    iir_re = 1; #1 chk("R6 no clr under ls", {7'b0, thre_clr_o}, 8'h00); cyc();
    lsr_rd = 1; cyc();
    expect_iir("R3 data after ls", 8'h04);
    // R4 timeout
    fifo_en = 1; rx_tmo = 1;
    expect_iir("R4 data beats timeout", 8'hC4);
    cyc();
    rx_avail = 0;
    expect_iir("R4 timeout code", 8'hCC);
    cyc();
    fifo_en = 0;
    expect_iir("R4 timeout needs fifo", 8'h02);
    cyc();
    rx_tmo = 0;
    iir_re = 1; cyc();
    expect_iir("R6 thre retired, modem left", 8'h00);
    msr_rd = 1; cyc();
    expect_iir("R5 modem cleared", 8'h01);
    // R8 masked source kept
    ier_we = 1; ier_wdata = 8'h00; cyc();
    lsr_evt = 1; cyc();
    expect_iir("R8 masked ls hidden", 8'h01);
    ier_we = 1; ier_wdata = 8'h04;
    expect_iir("R2 old enables in write cycle", 8'h01);
    cyc();
    expect_iir("R8 ls shows after enable", 8'h06);
    // R5 set beats clear
    lsr_evt = 1; lsr_rd = 1; cyc();
    expect_iir("R5 set wins", 8'h06);
    lsr_rd = 1; cyc();
    expect_iir("R5 cleared", 8'h01);
    // R6 set beats clear
    ier_we = 1; ier_wdata = 8'h02; cyc();
    thre_evt = 1; cyc();
    thre_evt = 1; iir_re = 1; cyc();
    expect_iir("R6 event beats read clear", 8'h02);
    // random phase
    for (int i = 0; i < 2000; i++) begin
      ier_we   = ($urandom_range(0, 15) == 0);
      ier_wdata = 8'($urandom);
      iir_re   = ($urandom_range(0, 3) == 0);
      lsr_evt  = ($urandom_range(0, 9) == 0);
      lsr_rd   = ($urandom_range(0, 5) == 0);
      thre_evt = ($urandom_range(0, 7) == 0);
      msr_evt  = ($urandom_range(0, 9) == 0);
      msr_rd   = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 7) == 0) rx_avail = ~rx_avail;
      if ($urandom_range(0, 7) == 0) rx_tmo   = ~rx_tmo;
      if ($urandom_range(0, 31) == 0) fifo_en = ~fifo_en;
      cyc();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule